// File: doc/BRIEF.md
# Configurable CRC Calculation Unit

This block keeps a running cyclic redundancy checksum over data words written into it. Before a message, the caller chooses one of four standard generator polynomials and loads a start value. It then writes the message as 8-, 16- or 32-bit words. The datapath consumes one byte per clock. A wide write therefore keeps the engine occupied for several cycles, and this is reported on a busy output while the ready output is held low.

Four independent switches condition the data. Two act on incoming bytes: one mirrors the bit order inside each byte and one inverts the bits. The other two act on the checksum presented at the output: one mirrors it across the full width of the chosen polynomial and one inverts it. With these switches, one engine produces both the MSB-first CRC variants and the reflected variants, with or without a final inversion. The start value is kept, so the calculation can be restarted for a new message without writing the seed again.

Top module: `crc_unit`

## Requirements
- R1: `poly_sel` chooses the generator: 0 = 0x1021 (16 bit), 1 = 0x07 (8 bit), 2 = 0x8005 (16 bit), 3 = 0x04C11DB7 (32 bit). `crc_out` bits at and above the chosen width read zero.
- R2: Each byte updates the state MSB-first with no implicit inversion. The result is the standard check value for the ASCII string "123456789" for the matching seed and switch settings.
- R3: A `seed_wr` pulse stores `seed_data` and loads it, masked to the chosen width, as the CRC state from the next cycle on.
- R4: A `restart` pulse reloads the CRC state from the stored seed.
- R5: `width_sel` 0 takes `data_in[7:0]`, 1 takes `data_in[15:0]`, and 2 or 3 take all 32 bits. Bytes are consumed least significant first, and bits above the selected width have no effect.
- R6: The first byte is absorbed at the accepting edge. `busy` is then high for exactly N-1 cycles for an N-byte write, so an 8-bit write never raises it.
- R7: `data_ready` is low while `busy`, `seed_wr` or `restart` is high. A `data_valid` seen while `data_ready` is low is ignored.
- R8: With `in_rev` set, the bit order inside every input byte is mirrored before use.
- R9: With `in_inv` set, every input bit is inverted before use.
- R10: With `out_rev` set, `crc_out` is the state mirrored across the chosen polynomial width.
- R11: With `out_inv` set, `crc_out` is inverted across the chosen polynomial width. Inversion is applied after mirroring.
- R12: After reset the state is zero, `busy` is low and `data_ready` is high.
- R13: `seed_wr` or `restart` during a multi-byte write drops the remaining bytes and clears `busy` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poly_sel | input | 2 | Polynomial choice |
| width_sel | input | 2 | Width of the current write |
| in_rev | input | 1 | Mirror bits within each input byte |
| in_inv | input | 1 | Invert input bits |
| out_rev | input | 1 | Mirror checksum across polynomial width |
| out_inv | input | 1 | Invert checksum across polynomial width |
| seed_wr | input | 1 | Store seed and load it as state |
| seed_data | input | 32 | Seed value |
| restart | input | 1 | Reload state from stored seed |
| data_valid | input | 1 | Data write request |
| data_in | input | 32 | Data word |
| data_ready | output | 1 | Write can be accepted this cycle |
| busy | output | 1 | Remaining bytes of a write are being absorbed |
| crc_out | output | 32 | Conditioned checksum, zero-extended |

## Verification
Each polynomial is run against its published check value for "123456789". Mixed write widths are used, with deliberate junk above the selected width. A design that takes bytes in the wrong order, reads the upper bits, or uses the wrong generator gives a different checksum. The reflected and inverted variants show whether mirroring is done per byte on input and across the full width on output. A design that mirrors the input across the whole word or the output per byte fails those vectors. A write issued while the engine is busy, and a restart issued in the middle of a word, expose designs that accept data during `busy` or that keep absorbing aborted bytes. Both show up as a wrong result or a wrong `busy` length.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'd0,
    POLY_CRC8  = 2'd1,
    POLY_CRC16 = 2'd2,
    POLY_CRC32 = 2'd3
  } poly_e;

  typedef enum logic [1:0] {
    WR_BYTE  = 2'd0,
    WR_HALF  = 2'd1,
    WR_WORD  = 2'd2,
    WR_WORD2 = 2'd3
  } wr_width_e;

  function automatic logic [5:0] poly_width(input logic [1:0] sel);
    case (poly_e'(sel))
      POLY_CRC8:  return 6'd8;
      POLY_CRC32: return 6'd32;
      default:    return 6'd16;
    endcase
  endfunction

  function automatic logic [31:0] poly_value(input logic [1:0] sel);
    case (poly_e'(sel))
      POLY_CCITT: return 32'h0000_1021;
      POLY_CRC8:  return 32'h0000_0007;
      POLY_CRC16: return 32'h0000_8005;
      default:    return 32'h04C1_1DB7;
    endcase
  endfunction

  // Left shift that aligns a polynomial-width value to bit 31.
  function automatic logic [5:0] poly_shift(input logic [1:0] sel);
    return 6'd32 - poly_width(sel);
  endfunction

  function automatic logic [31:0] poly_mask(input logic [1:0] sel);
    return 32'hFFFF_FFFF >> poly_shift(sel);
  endfunction

endpackage

// File: rtl/crc_in_shape.sv
module crc_in_shape #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic              rev_en,
  input  logic              inv_en,
  output logic [DATA_W-1:0] word_out
);

  localparam int NBYTES = DATA_W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] raw, mirrored;
    assign raw = word_in[g*8 +: 8];
    always_comb begin
      for (int i = 0; i < 8; i++) mirrored[i] = raw[7-i];
    end
    assign word_out[g*8 +: 8] = (rev_en ? mirrored : raw) ^ {8{inv_en}};
  end

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_pkg::*;
(
  input  logic [31:0] state_in,
  input  logic [7:0]  data_byte,
  input  logic [1:0]  poly_sel,
  output logic [31:0] state_out
);

  logic [5:0]  sh;
  logic [31:0] gen_top;
  logic [31:0] acc;

  // Work top-aligned so every polynomial width shares one shift chain.
  always_comb begin
    sh      = poly_shift(poly_sel);
    gen_top = poly_value(poly_sel) << sh;
    acc     = (state_in << sh) ^ {data_byte, 24'h0};
    for (int i = 0; i < 8; i++) begin
      acc = acc[31] ? ((acc << 1) ^ gen_top) : (acc << 1);
    end
    state_out = acc >> sh;
  end

endmodule

// File: rtl/crc_out_shape.sv
module crc_out_shape
  import crc_pkg::*;
(
  input  logic [31:0] state_in,
  input  logic [1:0]  poly_sel,
  input  logic        rev_en,
  input  logic        inv_en,
  output logic [31:0] crc_out
);

  logic [31:0] mirrored;
  logic [31:0] mask;
  logic [31:0] picked;

  always_comb begin
    for (int i = 0; i < 32; i++) mirrored[i] = state_in[31-i];
    mask    = poly_mask(poly_sel);
    picked  = rev_en ? (mirrored >> poly_shift(poly_sel)) : (state_in & mask);
    crc_out = picked ^ (inv_en ? mask : 32'h0);
  end

endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        poly_sel,
  input  logic [1:0]        width_sel,
  input  logic              in_rev,
  input  logic              in_inv,
  input  logic              out_rev,
  input  logic              out_inv,
  input  logic              seed_wr,
  input  logic [31:0]       seed_data,
  input  logic              restart,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  output logic              data_ready,
  output logic              busy,
  output logic [31:0]       crc_out
);

  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(NBYTES) + 1;

  logic [31:0]       state_q, state_d;
  logic [31:0]       seed_q;
  logic [DATA_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [DATA_W-1:0] shaped;
  logic [7:0]        step_byte;
  logic [31:0]       step_state;
  logic              load, accept, run_en;
  logic [CNT_W-1:0]  nbytes;

  crc_in_shape #(.DATA_W(DATA_W)) i_in_shape (
    .word_in  (data_in),
    .rev_en   (in_rev),
    .inv_en   (in_inv),
    .word_out (shaped)
  );

  crc_byte_step i_step (
    .state_in  (state_q),
    .data_byte (step_byte),
    .poly_sel  (poly_sel),
    .state_out (step_state)
  );

  crc_out_shape i_out_shape (
    .state_in (state_q),
    .poly_sel (poly_sel),
    .rev_en   (out_rev),
    .inv_en   (out_inv),
    .crc_out  (crc_out)
  );

  assign busy       = (left_q != '0);
  assign load       = seed_wr | restart;
  assign data_ready = ~busy & ~load;
  assign accept     = data_valid & data_ready;
  assign step_byte  = busy ? word_q[7:0] : shaped[7:0];
  assign run_en     = load | busy | accept;

  always_comb begin
    case (wr_width_e'(width_sel))
      WR_BYTE: nbytes = CNT_W'(1);
      WR_HALF: nbytes = CNT_W'(2);
      default: nbytes = CNT_W'(NBYTES);
    endcase
  end

  // Next state: seed write beats restart beats byte processing.
  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    left_d  = left_q;
    if (seed_wr) begin
      state_d = seed_data & poly_mask(poly_sel);
      left_d  = '0;
    end else if (restart) begin
      state_d = seed_q & poly_mask(poly_sel);
      left_d  = '0;
    end else if (busy) begin
      state_d = step_state;
      word_d  = word_q >> 8;
      left_d  = left_q - CNT_W'(1);
    end else if (accept) begin
      state_d = step_state;
      word_d  = shaped >> 8;
      left_d  = nbytes - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      word_q  <= '0;
      left_q  <= '0;
    end else if (run_en) begin
      state_q <= state_d;
      word_q  <= word_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seed_q <= '0;
    else if (seed_wr) seed_q <= seed_data;
  end

endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  poly_sel,
  input logic [1:0]  width_sel,
  input logic        seed_wr,
  input logic        restart,
  input logic        data_valid,
  input logic        data_ready,
  input logic        busy,
  input logic [31:0] crc_out,
  input logic [31:0] state_q
);

  assert_byte_write_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ready && width_sel == 2'd0) |=> !busy);

  assert_word_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ready && width_sel[1]) |=> busy);

  assert_reload_clears_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_wr || restart) |=> !busy);

  assert_crc8_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (poly_sel == 2'd1) |-> (crc_out[31:8] == 24'h0));

  assert_idle_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(data_valid && data_ready) && !seed_wr && !restart) |=> $stable(state_q));

endmodule

bind crc_unit crc_unit_chk i_crc_unit_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .poly_sel   (poly_sel),
  .width_sel  (width_sel),
  .seed_wr    (seed_wr),
  .restart    (restart),
  .data_valid (data_valid),
  .data_ready (data_ready),
  .busy       (busy),
  .crc_out    (crc_out),
  .state_q    (state_q)
);

// File: tb/test_crc_unit.sv
module test_crc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  poly_sel, width_sel;
  logic        in_rev, in_inv, out_rev, out_inv;
  logic        seed_wr, restart, data_valid;
  logic [31:0] seed_data, data_in;
  logic        data_ready, busy;
  logic [31:0] crc_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crc_unit i_crc_unit (
    .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .width_sel(width_sel),
    .in_rev(in_rev), .in_inv(in_inv), .out_rev(out_rev), .out_inv(out_inv),
    .seed_wr(seed_wr), .seed_data(seed_data), .restart(restart),
    .data_valid(data_valid), .data_in(data_in), .data_ready(data_ready),
    .busy(busy), .crc_out(crc_out)
  );

  // {poly, width, in_rev, in_inv, out_rev, out_inv, seed, expected} for "123456789"
  localparam logic [71:0] VEC [0:8] = '{
    {2'd3, 2'd0, 4'b0000, 32'hFFFF_FFFF, 32'h0376_E6E7}, // R1 R2 32-bit MSB-first
    {2'd3, 2'd0, 4'b1011, 32'hFFFF_FFFF, 32'hCBF4_3926}, // R8 R10 R11 reflected, inverted
    {2'd0, 2'd1, 4'b0000, 32'h0000_FFFF, 32'h0000_29B1}, // R5 16-bit writes
    {2'd1, 2'd2, 4'b0000, 32'h0000_0000, 32'h0000_00F4}, // R1 R5 8-bit poly, 32-bit writes
    {2'd2, 2'd0, 4'b1010, 32'h0000_0000, 32'h0000_BB3D}, // R8 R10 reflected 0x8005
    {2'd2, 2'd3, 4'b0000, 32'h0000_0000, 32'h0000_FEE8}, // R5 width code 3
    {2'd3, 2'd1, 4'b0100, 32'hFFFF_FFFF, 32'h0376_E6E7}, // R9 inverted feed
    {2'd0, 2'd0, 4'b0000, 32'h0000_0000, 32'h0000_31C3}, // R2 zero seed
    {2'd0, 2'd2, 4'b1010, 32'h0000_0000, 32'h0000_2189}  // R8 R10 reflected 0x1021
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model: bit-serial update, one message bit at a time.
  function automatic logic [31:0] ref_byte(input logic [1:0] ps, input logic [31:0] st,
                                           input logic [7:0] b);
    int w;
    logic [31:0] g, s;
    logic fb;
    w = (ps == 2'd1) ? 8 : (ps == 2'd3) ? 32 : 16;
    g = (ps == 2'd0) ? 32'h1021 : (ps == 2'd1) ? 32'h07 : (ps == 2'd2) ? 32'h8005 : 32'h04C11DB7;
    s = st;
    for (int i = 7; i >= 0; i--) begin
      fb = s[w-1] ^ b[i];
      s  = s << 1;
      if (fb) s = s ^ g;
      if (w < 32) s = s & ((32'h1 << w) - 32'h1);
    end
    return s;
  endfunction

  task automatic load_seed(input logic [31:0] s);
    seed_data = s; seed_wr = 1'b1;
    @(negedge clk);
    seed_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    while (!data_ready) @(negedge clk);
    width_sel = w; data_in = d; data_valid = 1'b1;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic feed_msg(input logic [1:0] wm, input logic inv);
    logic [7:0] m [0:8];
    for (int i = 0; i < 9; i++) m[i] = (8'h31 + 8'(i)) ^ {8{inv}};
    if (wm == 2'd0) begin
      for (int i = 0; i < 9; i++) wr(2'd0, {24'hC3A55A, m[i]});
    end else if (wm == 2'd1) begin
      for (int i = 0; i < 4; i++) wr(2'd1, {16'hDEAD, m[2*i+1], m[2*i]});
      wr(2'd0, {24'h5AA5C3, m[8]});
    end else begin
      for (int i = 0; i < 2; i++) wr(wm, {m[4*i+3], m[4*i+2], m[4*i+1], m[4*i]});
      wr(2'd0, {24'hFFFFFF, m[8]});
    end
    wait_idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R6 watchdog actual=hang expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0]  ps, wm;
    logic [3:0]  fl;
    logic [31:0] sd, ex, e;
    rst_n = 1'b0; poly_sel = '0; width_sel = '0; in_rev = 0; in_inv = 0;
    out_rev = 0; out_inv = 0; seed_wr = 0; restart = 0; data_valid = 0;
    seed_data = '0; data_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 crc_out after reset", crc_out, 32'h0);
    check("R12 busy after reset", {31'h0, busy}, 32'h0);
    check("R12 ready after reset", {31'h0, data_ready}, 32'h1);

    // Table of standard check values
    for (int v = 0; v < 9; v++) begin
      {ps, wm, fl, sd, ex} = VEC[v];
      poly_sel = ps; {in_rev, in_inv, out_rev, out_inv} = fl;
      load_seed(sd);
      feed_msg(wm, fl[2]);
      check($sformatf("R2 vector %0d", v), crc_out, ex);
    end

    // R3 seed masked to polynomial width; R10 / R11 output conditioning
    {in_rev, in_inv, out_rev, out_inv} = 4'b0000;
    poly_sel = 2'd1;
    load_seed(32'h1234_5678);
    check("R3 seed masked crc8", crc_out, 32'h78);
    poly_sel = 2'd0;
    load_seed(32'h0000_1234);
    out_rev = 1'b1;
    @(negedge clk);
    check("R10 mirror across 16 bits", crc_out, 32'h2C48);
    out_rev = 1'b0; out_inv = 1'b1;
    @(negedge clk);
    check("R11 invert across 16 bits", crc_out, 32'hEDCB);
    out_rev = 1'b1;
    @(negedge clk);
    check("R11 mirror then invert", crc_out, 32'hD3B7);
    out_rev = 1'b0; out_inv = 1'b0;

    // R4 restart reloads stored seed
    poly_sel = 2'd1;
    load_seed(32'h1234_5678);
    wr(2'd0, 32'h41);
    check("R4 byte changes state", crc_out, ref_byte(2'd1, 32'h78, 8'h41));
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    check("R4 restart reloads seed", crc_out, 32'h78);

    // R6 busy length, R7 writes during busy ignored
    load_seed(32'h0);
    width_sel = 2'd2; data_in = 32'h3433_3231; data_valid = 1'b1;
    @(negedge clk);
    check("R6 busy cycle 1", {31'h0, busy}, 32'h1);
    check("R7 ready low while busy", {31'h0, data_ready}, 32'h0);
    data_in = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R6 busy cycle 2", {31'h0, busy}, 32'h1);
    @(negedge clk);
    check("R6 busy cycle 3", {31'h0, busy}, 32'h1);
    data_valid = 1'b0;
    @(negedge clk);
    check("R6 busy drops after 4 bytes", {31'h0, busy}, 32'h0);
    e = 32'h0;
    for (int i = 0; i < 4; i++) e = ref_byte(2'd1, e, 8'h31 + 8'(i));
    check("R7 busy-time write ignored", crc_out, e);
    width_sel = 2'd1; data_in = 32'hAAAA_3536; data_valid = 1'b1;
    @(negedge clk);
    data_valid = 1'b0;
    check("R6 16-bit write busy one cycle", {31'h0, busy}, 32'h1);
    @(negedge clk);
    check("R6 16-bit write done", {31'h0, busy}, 32'h0);
    e = ref_byte(2'd1, ref_byte(2'd1, e, 8'h36), 8'h35);
    check("R5 low byte first", crc_out, e);

    // R13 restart during a word write drops remaining bytes
    poly_sel = 2'd3;
    load_seed(32'h0);
    width_sel = 2'd2; data_in = 32'h1122_3344; data_valid = 1'b1;
    @(negedge clk);
    data_valid = 1'b0; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check("R13 busy cleared by restart", {31'h0, busy}, 32'h0);
    check("R13 state back to seed", crc_out, 32'h0);
    wr(2'd0, 32'h31);
    check("R13 fresh byte after abort", crc_out, ref_byte(2'd3, 32'h0, 8'h31));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule